// File: doc/BRIEF.md
# Daisy-Chained Converter Readback Controller

This block sits on the host side of a three-wire link to a chain of 14-bit serial converters that share one convert strobe and one serial clock. When a start pulse arrives, or when the internal period timer expires with automatic mode enabled, the controller raises the convert strobe. It then waits for the conversion result in one of two ways, chosen per frame by a mode input. In plain mode it waits a fixed number of cycles that covers the longest conversion. In busy mode it watches the returning data line and starts as soon as that line goes high.

Once the wait is over, the controller generates a burst of serial clock pulses and captures the returning bit on each falling edge. It builds one word per converter in the chain and lowers the strobe when the burst ends. The words then leave on a valid/ready stream, nearest converter first. No new conversion begins until the last word of the frame has been accepted.

Top module: `chain_rd`

## Requirements
- R1: While reset is active and in the first cycle after it, `cnv_o`, `sck_o` and `word_valid_o` are all low.
- R2: The level of `sck_o` at the rising edge of `cnv_o` equals the frame's mode, as sampled from `busy_mode_i` when the frame starts (1 selects busy mode, 0 selects plain mode). That level does not change in the cycle in which `cnv_o` rises.
- R3: In plain mode, the first rising edge of `sck_o` comes no sooner than CONV_WAIT clock cycles after `cnv_o` rises.
- R4: In busy mode, no falling edge of `sck_o` occurs before `sdo_i` has been seen high while `cnv_o` is high.
- R5: Between a rise and the following fall of `cnv_o`, `sck_o` makes exactly NUM_ADC*14 falling edges in plain mode, and NUM_ADC*14+1 in busy mode.
- R6: `sck_o` never falls while `cnv_o` is low. `cnv_o` stays high from the start of a conversion until the readback burst has completed, and `sck_o` is low when `cnv_o` falls.
- R7: While `cnv_o` is high, every high phase and every low phase of `sck_o` lasts at least SCK_HALF clock cycles.
- R8: Each output word is formed from the `sdo_i` values sampled at successive `sck_o` falling edges, first sample into bit 13 (the sign bit of the two's complement code). Words are emitted in the order the bits arrive, so the word of the converter nearest the host comes first. In busy mode the bit sampled at the first falling edge is the start bit and is dropped.
- R9: Each frame yields exactly NUM_ADC words. While `word_valid_o` is high and `word_ready_i` is low, `word_valid_o` stays high and `word_o` holds its value.
- R10: `cnv_o` does not rise while any word of the previous frame is still unaccepted. A start request that arrives during that time is held and served afterwards.
- R11: With `auto_en_i` high and each frame finishing within the period, successive rising edges of `cnv_o` are exactly TRIG_PERIOD cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request for a conversion frame |
| auto_en_i | input | 1 | Enables the periodic trigger timer |
| busy_mode_i | input | 1 | Frame mode: 1 waits for the busy edge, 0 waits the fixed time |
| cnv_o | output | 1 | Convert strobe to the converter chain |
| sck_o | output | 1 | Serial clock to the converter chain |
| sdo_i | input | 1 | Serial data returning from the chain's near end |
| word_o | output | WORD_W | Captured converter word |
| word_valid_o | output | 1 | Stream valid |
| word_ready_i | input | 1 | Stream ready |

## Verification
The chain is modelled as one long shift register, loaded at the strobe edge with a start bit (busy mode only) ahead of the converters' words. Three kinds of word pattern are fed through it, and each one catches a different fault. Alternating sign-boundary codes (0x1FFF against 0x2000) show bit-order and slicing mistakes. All-ones against all-zeros words show off-by-one shifts between adjacent converters. Random words show lost or duplicated bits.

Busy frames are run with a one-cycle delay and with a delay near the fixed wait. This separates a controller that truly waits for the data edge from one that waits a fixed time, and the short delay also shows whether the start bit is wrongly kept as data. The ready input is held high, toggled at random, and held low through a start request. These cases distinguish correct stalling and trigger blocking from a stream that drops or repeats words. A periodic run shows whether the strobe spacing drifts from the set period.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;
  typedef enum logic [2:0] {
    RD_IDLE,
    RD_PREP,
    RD_CONV,
    RD_SHIFT,
    RD_DRAIN
  } rd_state_e;
endpackage

// File: rtl/chain_rd_sckgen.sv
// Serial clock burst generator: high half then low half per pulse.
module chain_rd_sckgen #(
  parameter int SCK_HALF = 2,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] pulses_i,
  output logic             sck_hi_o,
  output logic             sample_o,
  output logic             first_o,
  output logic             last_o
);
  localparam int HW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  logic [HW-1:0]    half_q, half_d;
  logic             low_q, low_d;
  logic [CNT_W-1:0] pc_q, pc_d;
  logic             half_end;

  assign half_end = (half_q == HW'(SCK_HALF - 1));

  always_comb begin
    half_d = half_q;
    low_d  = low_q;
    pc_d   = pc_q;
    if (!run_i) begin
      half_d = '0;
      low_d  = 1'b0;
      pc_d   = '0;
    end else if (half_end) begin
      half_d = '0;
      low_d  = !low_q;
      if (low_q) pc_d = pc_q + 1'b1;
    end else begin
      half_d = half_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      low_q  <= 1'b0;
      pc_q   <= '0;
    end else begin
      half_q <= half_d;
      low_q  <= low_d;
      pc_q   <= pc_d;
    end
  end

  assign sck_hi_o = run_i && !low_q;
  assign sample_o = run_i && !low_q && half_end;
  assign first_o  = (pc_q == '0);
  assign last_o   = run_i && low_q && half_end && (pc_q == pulses_i - 1'b1);
endmodule

// File: rtl/chain_rd_deser.sv
// Collects the whole chain's bits, then releases them a word at a time.
module chain_rd_deser #(
  parameter int NUM_ADC = 3,
  parameter int WORD_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int BUF_W = NUM_ADC * WORD_W;

  logic [BUF_W-1:0] sreg_q, sreg_d;

  always_comb begin
    sreg_d = sreg_q;
    if (shift_i)    sreg_d = {sreg_q[BUF_W-2:0], bit_i};
    else if (pop_i) sreg_d = sreg_q << WORD_W;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= sreg_d;
  end

  assign word_o = sreg_q[BUF_W-1 -: WORD_W];
endmodule

// File: rtl/chain_rd_seq.sv
// Frame sequencer: trigger, strobe, conversion wait, burst, drain.
module chain_rd_seq
  import chain_rd_pkg::*;
#(
  parameter int NUM_ADC     = 3,
  parameter int CONV_WAIT   = 40,
  parameter int TRIG_PERIOD = 400
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      auto_en_i,
  input  logic      busy_mode_i,
  input  logic      sdo_i,
  input  logic      burst_last_i,
  input  logic      word_ready_i,
  output rd_state_e state_o,
  output logic      mode_o,
  output logic      cnv_o,
  output logic      word_valid_o,
  output logic      pop_o
);
  localparam int CW_W = $clog2(CONV_WAIT + 1);
  localparam int TP_W = $clog2(TRIG_PERIOD + 1);
  localparam int WC_W = $clog2(NUM_ADC + 1);

  rd_state_e   state_q, state_d;
  logic        mode_q, mode_d;
  logic        pend_q, pend_d;
  logic [CW_W-1:0] wait_q, wait_d;
  logic [TP_W-1:0] per_q, per_d;
  logic [WC_W-1:0] wc_q, wc_d;
  logic        tick;

  assign tick = auto_en_i && (per_q == TP_W'(TRIG_PERIOD - 1));

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    wait_d  = wait_q;
    wc_d    = wc_q;
    pend_d  = pend_q | start_i | tick;
    if (!auto_en_i) per_d = '0;
    else if (tick)  per_d = '0;
    else            per_d = per_q + 1'b1;

    unique case (state_q)
      RD_IDLE: begin
        if (pend_q) begin
          pend_d  = start_i | tick;
          mode_d  = busy_mode_i;
          state_d = RD_PREP;
        end
      end
      RD_PREP: begin
        wait_d  = '0;
        state_d = RD_CONV;
      end
      RD_CONV: begin
        if (mode_q) begin
          if (sdo_i) state_d = RD_SHIFT;
        end else if (wait_q == CW_W'(CONV_WAIT - 1)) begin
          state_d = RD_SHIFT;
        end else begin
          wait_d = wait_q + 1'b1;
        end
      end
      RD_SHIFT: begin
        if (burst_last_i) begin
          wc_d    = '0;
          state_d = RD_DRAIN;
        end
      end
      RD_DRAIN: begin
        if (word_ready_i) begin
          if (wc_q == WC_W'(NUM_ADC - 1)) state_d = RD_IDLE;
          else                            wc_d    = wc_q + 1'b1;
        end
      end
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      mode_q  <= 1'b0;
      pend_q  <= 1'b0;
      wait_q  <= '0;
      per_q   <= '0;
      wc_q    <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      pend_q  <= pend_d;
      wait_q  <= wait_d;
      per_q   <= per_d;
      wc_q    <= wc_d;
    end
  end

  assign state_o      = state_q;
  assign mode_o       = mode_q;
  assign cnv_o        = (state_q == RD_CONV) || (state_q == RD_SHIFT);
  assign word_valid_o = (state_q == RD_DRAIN);
  assign pop_o        = (state_q == RD_DRAIN) && word_ready_i;
endmodule

// File: rtl/chain_rd.sv
module chain_rd
  import chain_rd_pkg::*;
#(
  parameter int NUM_ADC     = 3,
  parameter int WORD_W      = 14,
  parameter int SCK_HALF    = 2,
  parameter int CONV_WAIT   = 40,
  parameter int TRIG_PERIOD = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              auto_en_i,
  input  logic              busy_mode_i,
  output logic              cnv_o,
  output logic              sck_o,
  input  logic              sdo_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  input  logic              word_ready_i
);
  localparam int BITS    = NUM_ADC * WORD_W;
  localparam int PULSE_W = $clog2(BITS + 2);

  rd_state_e          state;
  logic               mode, pop, sck_hi, sample, first, last;
  logic [PULSE_W-1:0] pulses;

  assign pulses = PULSE_W'(BITS) + {{(PULSE_W-1){1'b0}}, mode};

  chain_rd_seq #(
    .NUM_ADC(NUM_ADC), .CONV_WAIT(CONV_WAIT), .TRIG_PERIOD(TRIG_PERIOD)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .auto_en_i(auto_en_i),
    .busy_mode_i(busy_mode_i), .sdo_i(sdo_i), .burst_last_i(last),
    .word_ready_i(word_ready_i), .state_o(state), .mode_o(mode),
    .cnv_o(cnv_o), .word_valid_o(word_valid_o), .pop_o(pop)
  );

  chain_rd_sckgen #(.SCK_HALF(SCK_HALF), .CNT_W(PULSE_W)) u_sck (
    .clk(clk), .rst_n(rst_n), .run_i(state == RD_SHIFT), .pulses_i(pulses),
    .sck_hi_o(sck_hi), .sample_o(sample), .first_o(first), .last_o(last)
  );

  chain_rd_deser #(.NUM_ADC(NUM_ADC), .WORD_W(WORD_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .shift_i(sample && !(mode && first)),
    .bit_i(sdo_i), .pop_i(pop), .word_o(word_o)
  );

  always_comb begin
    unique case (state)
      RD_PREP, RD_CONV: sck_o = mode;
      RD_SHIFT:         sck_o = sck_hi;
      default:          sck_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/chain_rd_chk.sv
module chain_rd_chk #(
  parameter int NUM_ADC   = 3,
  parameter int WORD_W    = 14,
  parameter int SCK_HALF  = 2,
  parameter int CONV_WAIT = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnv_o,
  input logic              sck_o,
  input logic              sdo_i,
  input logic              word_valid_o,
  input logic              word_ready_i,
  input logic [WORD_W-1:0] word_o
);
  localparam int FW = $clog2(NUM_ADC * WORD_W + 2) + 1;
  localparam int CW = $clog2(CONV_WAIT + 2);
  localparam int RW = $clog2(SCK_HALF + 2);

  logic          sck_d, cnv_d, mode_q, seen_q;
  logic [FW-1:0] falls_q;
  logic [CW-1:0] cyc_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0; cnv_d <= 1'b0; mode_q <= 1'b0; seen_q <= 1'b0;
      falls_q <= '0; cyc_q <= '0; run_q <= '0;
    end else begin
      sck_d <= sck_o;
      cnv_d <= cnv_o;
      if (sck_o != sck_d)              run_q <= RW'(1);
      else if (run_q != RW'(SCK_HALF)) run_q <= run_q + 1'b1;
      if (cnv_o && !cnv_d) mode_q <= sck_o;
      if (!cnv_o) begin
        cyc_q <= '0; seen_q <= 1'b0; falls_q <= '0;
      end else begin
        if (cyc_q != CW'(CONV_WAIT)) cyc_q <= cyc_q + 1'b1;
        if (sdo_i) seen_q <= 1'b1;
        if (sck_d && !sck_o) falls_q <= falls_q + 1'b1;
      end
    end
  end

  // R2
  sck_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_o && !cnv_d |-> sck_o == sck_d);
  // R3
  conv_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_o && cnv_d && !mode_q && sck_o && !sck_d |-> cyc_q >= CW'(CONV_WAIT));
  // R4
  busy_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_o && cnv_d && mode_q && sck_d && !sck_o |-> seen_q);
  // R5
  pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnv_o && cnv_d |-> falls_q == FW'(NUM_ADC * WORD_W) + FW'(mode_q));
  // R6
  fall_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_d && !sck_o |-> cnv_o);
  // R7
  sck_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_o && (sck_o != sck_d) |-> run_q >= RW'(SCK_HALF));
  // R9
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o && !word_ready_i |=> word_valid_o && $stable(word_o));
  // R10
  no_cnv_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> !cnv_o);
endmodule

bind chain_rd chain_rd_chk #(
  .NUM_ADC(NUM_ADC), .WORD_W(WORD_W), .SCK_HALF(SCK_HALF), .CONV_WAIT(CONV_WAIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnv_o(cnv_o), .sck_o(sck_o), .sdo_i(sdo_i),
  .word_valid_o(word_valid_o), .word_ready_i(word_ready_i), .word_o(word_o)
);

// File: tb/chain_rd_test.sv
`timescale 1ns/1ps
module chain_rd_test;
  localparam int NA  = 3;
  localparam int W   = 14;
  localparam int SH  = 2;
  localparam int CW  = 40;
  localparam int TP  = 400;
  localparam int TOP = NA * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, auto_en_i = 1'b0, busy_mode_i = 1'b0, word_ready_i = 1'b1;
  logic cnv_o, sck_o, sdo_i, word_valid_o;
  logic [W-1:0] word_o;

  always #10 clk = ~clk;

  chain_rd #(.NUM_ADC(NA), .WORD_W(W), .SCK_HALF(SH), .CONV_WAIT(CW), .TRIG_PERIOD(TP)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .auto_en_i(auto_en_i),
    .busy_mode_i(busy_mode_i), .cnv_o(cnv_o), .sck_o(sck_o), .sdo_i(sdo_i),
    .word_o(word_o), .word_valid_o(word_valid_o), .word_ready_i(word_ready_i)
  );

  int errors = 0, checks = 0;
  logic [W-1:0] exp_w [NA];
  logic [W-1:0] cur_w [NA];
  logic [TOP:0] sr;
  logic armed;
  int   dly_cnt, busy_dly, rdy_mode;
  logic cnv_p, sck_p, frame_mode, phase_bad, r3_done, r4_done, stall_flag;
  logic [W-1:0] stall_word;
  int cyc, run, falls, widx, done_cnt, r6_viol, now_cyc, nrise;
  int rise_t [8];
  bit auto_on, wd_fired;

  assign sdo_i = armed & sr[TOP];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat_word(input int pat, input int i);
    case (pat)
      1:       return (i % 2 == 1) ? 14'h2000 : 14'h1FFF;
      2:       return (i % 2 == 1) ? 14'h0000 : 14'h3FFF;
      default: return W'($urandom);
    endcase
  endfunction

  // ready driver, away from the sampling edge
  always @(posedge clk) begin
    #2;
    case (rdy_mode)
      0:       word_ready_i = 1'b1;
      1:       word_ready_i = 1'($urandom % 2);
      default: word_ready_i = 1'b0;
    endcase
  end

  // chain model and monitor
  always @(negedge clk) begin
    now_cyc++;
    if (now_cyc > 150000 && !wd_fired) begin
      wd_fired = 1;
      chk(0, "watchdog", now_cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (rst_n) begin
      // conversion start
      if (cnv_o && !cnv_p) begin
        chk(sck_o == busy_mode_i, "R2", sck_o, busy_mode_i);
        chk(widx == NA, "R10", widx, NA);
        frame_mode = busy_mode_i;
        if (auto_on && nrise < 8) begin rise_t[nrise] = now_cyc; nrise++; end
        cyc = 0; falls = 0; phase_bad = 0; r3_done = 0; r4_done = 0; run = SH;
        widx = 0; stall_flag = 0;
        for (int i = 0; i < NA; i++) cur_w[i] = exp_w[i];
        sr = '0;
        if (frame_mode) begin
          sr[TOP] = 1'b1;
          for (int i = 0; i < NA; i++) sr[TOP-1-i*W -: W] = cur_w[i];
          armed = 1'b0;
          dly_cnt = busy_dly;
        end else begin
          for (int i = 0; i < NA; i++) sr[TOP-i*W -: W] = cur_w[i];
          armed = 1'b1;
        end
      end else if (cnv_o) begin
        cyc++;
        if (sck_o != sck_p) begin
          if (run < SH) phase_bad = 1;
          run = 1;
        end else run++;
        if (sck_o && !sck_p && !frame_mode && !r3_done) begin
          r3_done = 1;
          chk(cyc >= CW, "R3", cyc, CW);
        end
        if (!sck_o && sck_p) begin
          if (frame_mode && !r4_done) begin
            r4_done = 1;
            chk(armed, "R4", armed, 1);
          end
          falls++;
          sr = sr << 1;
        end
        if (!armed) begin
          if (dly_cnt <= 1) armed = 1'b1;
          else dly_cnt--;
        end
      end
      if (!cnv_o && !sck_o && sck_p) r6_viol++;
      // conversion end
      if (!cnv_o && cnv_p) begin
        chk(falls == TOP + int'(frame_mode), "R5", falls, TOP + int'(frame_mode));
        chk(!sck_o && r6_viol == 0, "R6", r6_viol, 0);
        chk(!phase_bad, "R7", phase_bad, 0);
        armed = 1'b0;
      end
      // output stream
      if (word_valid_o) begin
        if (stall_flag) chk(word_o == stall_word, "R9", word_o, stall_word);
        if (widx >= NA) chk(0, "R9", widx, NA - 1);
        else if (word_ready_i) begin
          chk(word_o == cur_w[widx], "R8", word_o, cur_w[widx]);
          widx++;
          if (widx == NA) done_cnt++;
          stall_flag = 0;
        end else begin
          stall_flag = 1;
          stall_word = word_o;
        end
      end
    end
    cnv_p = cnv_o;
    sck_p = sck_o;
  end

  task automatic run_frame(input bit m, input int d, input int rmode, input int pat);
    int tgt;
    for (int i = 0; i < NA; i++) exp_w[i] = pat_word(pat, i);
    @(posedge clk); #2;
    busy_mode_i = m; busy_dly = d; rdy_mode = rmode;
    tgt = done_cnt + 1;
    start_i = 1'b1;
    @(posedge clk); #2;
    start_i = 1'b0;
    wait (done_cnt == tgt);
  endtask

  initial begin
    int tgt;
    void'($urandom(32'd1234));
    cnv_p = 0; sck_p = 0; armed = 0; sr = '0; widx = NA; done_cnt = 0;
    r6_viol = 0; now_cyc = 0; nrise = 0; rdy_mode = 0; busy_dly = 1;
    frame_mode = 0; stall_flag = 0;
    for (int i = 0; i < NA; i++) begin exp_w[i] = '0; cur_w[i] = '0; end
    repeat (3) @(negedge clk);
    chk(!cnv_o && !sck_o && !word_valid_o, "R1", {cnv_o, sck_o, word_valid_o}, 0);
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    chk(!cnv_o && !sck_o && !word_valid_o, "R1", {cnv_o, sck_o, word_valid_o}, 0);

    // directed corners: sign boundary, busy with shortest delay, long delay
    run_frame(1'b0, 1, 0, 1);
    run_frame(1'b1, 1, 0, 2);
    run_frame(1'b1, 40, 1, 0);
    run_frame(1'b0, 1, 1, 2);

    // R10: start request while words wait for acceptance
    for (int i = 0; i < NA; i++) exp_w[i] = pat_word(0, i);
    @(posedge clk); #2;
    busy_mode_i = 1'b0; rdy_mode = 2; tgt = done_cnt + 2;
    start_i = 1'b1;
    @(posedge clk); #2 start_i = 1'b0;
    wait (word_valid_o);
    @(posedge clk); #2 start_i = 1'b1;
    @(posedge clk); #2 start_i = 1'b0;
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk(!cnv_o && word_valid_o, "R10", {cnv_o, word_valid_o}, 1);
    rdy_mode = 1;
    wait (done_cnt == tgt);

    // random frames
    for (int f = 0; f < 20; f++)
      run_frame(1'($urandom % 2), 1 + int'($urandom % 40), int'($urandom % 2), 0);

    // R11: periodic trigger
    for (int i = 0; i < NA; i++) exp_w[i] = pat_word(0, i);
    @(posedge clk); #2;
    busy_mode_i = 1'b0; rdy_mode = 0; auto_on = 1; auto_en_i = 1'b1;
    wait (nrise >= 4);
    for (int k = 1; k < 4; k++)
      chk(rise_t[k] - rise_t[k-1] == TP, "R11", rise_t[k] - rise_t[k-1], TP);
    @(posedge clk); #2 auto_en_i = 1'b0;
    repeat (TP + 50) @(posedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule